// File: doc/BRIEF.md
# Load-Pair-and-Broadcast Vector Unit

This unit executes one vector instruction. The instruction reads two consecutive elements of memory and copies each element into every lane of its own vector destination register. The caller presents a 32-bit instruction word with a one-cycle `start` strobe while `idle` is high. The unit checks whether the word is one of the two legal forms: the plain form, or the form that writes back the base afterwards. It takes the base address from a scalar register read port. When the base field selects index 31, it takes the base from the stack-pointer input instead.

The unit then makes two element reads in order over a valid/ready request channel. Each read is answered by a response-valid strobe. The first read uses the base address. The second uses the base plus one element size in bytes. After both responses arrive, a single `done` cycle presents everything at once: both vector register writes and, in the write-back form, the updated base value.

A word that is not a legal form produces an `illegal` pulse. A stack-pointer base that is not 16-byte aligned produces a `fault` pulse. In both cases the unit makes no memory access and commits nothing.

Top module: `ldrep_unit`

## Requirements
- R1: A word is legal only when bit31=0, bits29:23 are 0011010 (plain) or 0011011 (write-back), bits22:21=11, bits15:13=110 and bit12=0. In the plain form, bits20:16 must also be zero. An illegal word gives a one-cycle `illegal` pulse in the cycle after `start` and makes no memory request.
- R2: The first read goes to the base address and the second to the base plus 2^size bytes, in that order. `mem_req_size` carries the size field, and the element is taken from the low 8·2^size bits of `mem_rsp_data`.
- R3: The first element fills every lane of register Rt (bits4:0). The second element fills every lane of register (Rt+1) mod 32. The size field (bits11:10) encodes 00=8, 01=16, 10=32 and 11=64-bit lanes.
- R4: With Q (bit30) = 1, all 128 bits are filled. With Q = 0, bits 63:0 are filled and bits 127:64 are zero.
- R5: Base index Rn (bits9:5) = 31 selects `sp_val` as the base, and any other index selects `gpr_ra_data`. A stack-pointer base whose bits 3:0 are not all zero gives a one-cycle `fault` pulse, with no request and no `done`.
- R6: In the write-back form, `base_wr_en` is high during `done`. When Rm (bits20:16) = 31, `base_wr_data` is the base plus 2·2^size. Otherwise it is the base plus `gpr_rb_data`. `base_wr_sp` is high when Rn=31, and `base_wr_idx` carries Rn. In the plain form, `base_wr_en` stays low.
- R7: A request that is not accepted stays valid with an unchanged address until `mem_req_ready` is high.
- R8: `done` is a single-cycle pulse in which both vector writes and the base write are presented together. A `start` while `idle` is low is ignored.
- R9: After reset, the unit is idle, with `done`, `illegal`, `fault`, `base_wr_en` and `mem_req_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction strobe, taken only while idle |
| instr | input | 32 | Instruction word |
| idle | output | 1 | Unit can accept an instruction |
| gpr_ra_idx | output | 5 | Base register read index (Rn) |
| gpr_ra_data | input | 64 | Base register read data |
| gpr_rb_idx | output | 5 | Offset register read index (Rm) |
| gpr_rb_data | input | 64 | Offset register read data |
| sp_val | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read byte address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data, element in low bits |
| done | output | 1 | Commit pulse |
| illegal | output | 1 | Unrecognised instruction pulse |
| fault | output | 1 | Misaligned stack base pulse |
| vreg_a_idx | output | 5 | First destination register index |
| vreg_a_data | output | 128 | First destination value |
| vreg_b_idx | output | 5 | Second destination register index |
| vreg_b_data | output | 128 | Second destination value |
| base_wr_en | output | 1 | Base write-back enable |
| base_wr_sp | output | 1 | Write-back goes to the stack pointer |
| base_wr_idx | output | 5 | Write-back register index |
| base_wr_data | output | 64 | Updated base value |

## Verification
A table of instructions covers every element size under both register widths, in both forms and with both write-back offset sources. Because each memory byte has a distinct address-derived value, a wrong lane width, a wrong byte order or a wrong second address all show up in the broadcast data. One table row has Rt=31 to expose a missing wrap of the second index. Another row uses Q=0 with 64-bit lanes, which catches upper-half leakage. Giving the scalar register and the stack pointer different bases shows which source was used. Directed cases cover illegal words, a misaligned stack base, and a start strobe that arrives while the unit is busy.

// File: rtl/ldrep_pkg.sv
package ldrep_pkg;

   typedef struct packed {
      logic       legal;
      logic       post;
      logic       q;
      logic [1:0] size;
      logic [4:0] rm;
      logic [4:0] rn;
      logic [4:0] rt;
   } ldrep_dec_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD0,
      ST_WT0,
      ST_RD1,
      ST_WT1,
      ST_CMT
   } ldrep_state_t;

   localparam logic [4:0] SP_INDEX = 5'd31;

endpackage

// File: rtl/ldrep_decode.sv
module ldrep_decode
   import ldrep_pkg::*;
#(
   parameter int IW = 32
) (
   input  logic [IW-1:0] word,
   output ldrep_dec_t    dec
);
   localparam logic [6:0] OPC_PLAIN = 7'b0011010;
   localparam logic [6:0] OPC_POST  = 7'b0011011;

   if (IW != 32) begin : g_bad_iw
      $error("ldrep_decode: IW must be 32");
   end

   logic common_ok, plain_ok, post_ok;

   always_comb begin
      common_ok = (word[31] == 1'b0) && (word[22:21] == 2'b11) &&
                  (word[15:13] == 3'b110) && (word[12] == 1'b0);
      plain_ok  = common_ok && (word[29:23] == OPC_PLAIN) && (word[20:16] == 5'd0);
      post_ok   = common_ok && (word[29:23] == OPC_POST);
      dec.legal = plain_ok || post_ok;
      dec.post  = post_ok;
      dec.q     = word[30];
      dec.size  = word[11:10];
      dec.rm    = word[20:16];
      dec.rn    = word[9:5];
      dec.rt    = word[4:0];
   end
endmodule

// File: rtl/ldrep_bcast.sv
module ldrep_bcast #(
   parameter int VLEN     = 128,
   parameter int ELEM_MAX = 64
) (
   input  logic [ELEM_MAX-1:0] elem,
   input  logic [1:0]          size,
   input  logic                q,
   output logic [VLEN-1:0]     vec
);
   localparam int NSIZE = $clog2(ELEM_MAX / 8) + 1;
   localparam int HALF  = VLEN / 2;

   if (VLEN != 128) begin : g_bad_vlen
      $error("ldrep_bcast: VLEN must be 128");
   end
   if (ELEM_MAX != 64) begin : g_bad_emax
      $error("ldrep_bcast: ELEM_MAX must be 64");
   end

   logic [VLEN-1:0] rep [NSIZE];

   for (genvar s = 0; s < NSIZE; s++) begin : g_size
      localparam int EW = 8 << s;
      assign rep[s] = {(VLEN / EW){elem[EW-1:0]}};
   end

   always_comb begin
      vec = rep[size];
      if (!q) vec[VLEN-1:HALF] = '0;
   end
endmodule

// File: rtl/ldrep_seq.sv
module ldrep_seq
   import ldrep_pkg::*;
#(
   parameter int AW       = 64,
   parameter int ELEM_MAX = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  ldrep_dec_t          dec,
   input  logic [AW-1:0]       gpr_base,
   input  logic [AW-1:0]       gpr_off,
   input  logic [AW-1:0]       sp_val,
   output logic                idle,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [AW-1:0]       mem_req_addr,
   output logic [1:0]          mem_req_size,
   input  logic                mem_rsp_valid,
   input  logic [ELEM_MAX-1:0] mem_rsp_data,
   output logic                done,
   output logic                illegal,
   output logic                fault,
   output ldrep_dec_t          dec_r,
   output logic [ELEM_MAX-1:0] elem0,
   output logic [ELEM_MAX-1:0] elem1,
   output logic [AW-1:0]       wb_val
);
   localparam int SP_ALIGN_BITS = 4;

   if (AW < 16) begin : g_bad_aw
      $error("ldrep_seq: AW too small");
   end

   ldrep_state_t  state;
   logic [AW-1:0] base_r;
   logic [AW-1:0] esz_now, esz_r, src_base, offset;

   always_comb begin
      esz_now  = AW'(1) << dec.size;
      esz_r    = AW'(1) << dec_r.size;
      src_base = (dec.rn == SP_INDEX) ? sp_val : gpr_base;
      if (dec.rm == SP_INDEX) offset = esz_now << 1;
      else                    offset = gpr_off;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_r  <= '0;
         wb_val  <= '0;
         dec_r   <= '0;
         elem0   <= '0;
         elem1   <= '0;
         illegal <= 1'b0;
         fault   <= 1'b0;
      end else begin
         illegal <= 1'b0;
         fault   <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               if (!dec.legal) begin
                  illegal <= 1'b1;
               end else if ((dec.rn == SP_INDEX) &&
                            (sp_val[SP_ALIGN_BITS-1:0] != '0)) begin
                  fault <= 1'b1;
               end else begin
                  dec_r  <= dec;
                  base_r <= src_base;
                  wb_val <= src_base + offset;
                  state  <= ST_RD0;
               end
            end
            ST_RD0: if (mem_req_ready) state <= ST_WT0;
            ST_WT0: if (mem_rsp_valid) begin
               elem0 <= mem_rsp_data;
               state <= ST_RD1;
            end
            ST_RD1: if (mem_req_ready) state <= ST_WT1;
            ST_WT1: if (mem_rsp_valid) begin
               elem1 <= mem_rsp_data;
               state <= ST_CMT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle          = (state == ST_IDLE);
   assign done          = (state == ST_CMT);
   assign mem_req_valid = (state == ST_RD0) || (state == ST_RD1);
   assign mem_req_addr  = (state == ST_RD1) ? base_r + esz_r : base_r;
   assign mem_req_size  = dec_r.size;

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
   assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, illegal, fault}));
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !mem_req_valid && idle);
   assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !mem_req_valid && idle);
endmodule

// File: rtl/ldrep_unit.sv
module ldrep_unit
   import ldrep_pkg::*;
#(
   parameter int AW       = 64,
   parameter int VLEN     = 128,
   parameter int ELEM_MAX = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [31:0]         instr,
   output logic                idle,
   output logic [4:0]          gpr_ra_idx,
   input  logic [AW-1:0]       gpr_ra_data,
   output logic [4:0]          gpr_rb_idx,
   input  logic [AW-1:0]       gpr_rb_data,
   input  logic [AW-1:0]       sp_val,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [AW-1:0]       mem_req_addr,
   output logic [1:0]          mem_req_size,
   input  logic                mem_rsp_valid,
   input  logic [ELEM_MAX-1:0] mem_rsp_data,
   output logic                done,
   output logic                illegal,
   output logic                fault,
   output logic [4:0]          vreg_a_idx,
   output logic [VLEN-1:0]     vreg_a_data,
   output logic [4:0]          vreg_b_idx,
   output logic [VLEN-1:0]     vreg_b_data,
   output logic                base_wr_en,
   output logic                base_wr_sp,
   output logic [4:0]          base_wr_idx,
   output logic [AW-1:0]       base_wr_data
);
   ldrep_dec_t          dec, dec_r;
   logic [ELEM_MAX-1:0] elem0, elem1;
   logic [AW-1:0]       wb_val;

   ldrep_decode #(.IW(32)) i_dec (.word(instr), .dec(dec));

   assign gpr_ra_idx = dec.rn;
   assign gpr_rb_idx = dec.rm;

   ldrep_seq #(.AW(AW), .ELEM_MAX(ELEM_MAX)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dec(dec),
      .gpr_base(gpr_ra_data), .gpr_off(gpr_rb_data), .sp_val(sp_val),
      .idle(idle), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .illegal(illegal), .fault(fault), .dec_r(dec_r),
      .elem0(elem0), .elem1(elem1), .wb_val(wb_val));

   ldrep_bcast #(.VLEN(VLEN), .ELEM_MAX(ELEM_MAX)) i_bc0 (
      .elem(elem0), .size(dec_r.size), .q(dec_r.q), .vec(vreg_a_data));
   ldrep_bcast #(.VLEN(VLEN), .ELEM_MAX(ELEM_MAX)) i_bc1 (
      .elem(elem1), .size(dec_r.size), .q(dec_r.q), .vec(vreg_b_data));

   assign vreg_a_idx   = dec_r.rt;
   assign vreg_b_idx   = dec_r.rt + 5'd1;
   assign base_wr_en   = done && dec_r.post;
   assign base_wr_sp   = (dec_r.rn == SP_INDEX);
   assign base_wr_idx  = dec_r.rn;
   assign base_wr_data = wb_val;

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> vreg_b_idx == vreg_a_idx + 5'd1);
   assert_narrow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done && !dec_r.q |-> vreg_a_data[VLEN-1:VLEN/2] == '0 && vreg_b_data[VLEN-1:VLEN/2] == '0);
   assert_wb_only_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr_en |-> done);
endmodule

// File: tb/test_ldrep_unit.sv
module test_ldrep_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        post;
      logic        q;
      logic [1:0]  size;
      logic [4:0]  rn;
      logic [4:0]  rm;
      logic [4:0]  rt;
      logic [63:0] base;
      logic [63:0] off;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 2'd0, 5'd3,  5'd0,  5'd5,  64'h1000, 64'h0},
      '{1'b0, 1'b1, 2'd1, 5'd7,  5'd0,  5'd10, 64'h2002, 64'h0},
      '{1'b0, 1'b1, 2'd2, 5'd2,  5'd0,  5'd31, 64'h0030, 64'h0},
      '{1'b0, 1'b0, 2'd3, 5'd4,  5'd0,  5'd0,  64'h4000, 64'h0},
      '{1'b1, 1'b1, 2'd3, 5'd6,  5'd31, 5'd12, 64'h0100, 64'h0},
      '{1'b1, 1'b0, 2'd2, 5'd8,  5'd9,  5'd1,  64'h0200, 64'h44},
      '{1'b1, 1'b1, 2'd0, 5'd31, 5'd31, 5'd20, 64'h8000, 64'h0},
      '{1'b0, 1'b0, 2'd1, 5'd31, 5'd0,  5'd30, 64'h7FF0, 64'h0}
   };
   localparam logic [63:0] GPR_BIAS = 64'h0100_0000_0000;

   logic clk = 0, rst_n = 0, start = 0;
   logic [31:0] instr = '0;
   logic idle, mem_req_valid, mem_req_ready, mem_rsp_valid = 0;
   logic [4:0] gpr_ra_idx, gpr_rb_idx, vreg_a_idx, vreg_b_idx, base_wr_idx;
   logic [63:0] gpr_ra_data = '0, gpr_rb_data = '0, sp_val = '0, mem_rsp_data = '0;
   logic [63:0] mem_req_addr, base_wr_data;
   logic [1:0] mem_req_size;
   logic done, illegal, fault, base_wr_en, base_wr_sp;
   logic [127:0] vreg_a_data, vreg_b_data;

   int checks = 0, fails = 0, cyc = 0, nreq = 0;
   logic [63:0] log_addr [4];
   logic [1:0]  log_size [4];

   ldrep_unit i_ldrep_unit (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] memb(input logic [63:0] a);
      return (a[7:0] * 8'd37 + 8'd11) ^ a[15:8];
   endfunction
   function automatic logic [63:0] memval(input logic [63:0] a);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[k*8 +: 8] = memb(a + 64'(k));
      return r;
   endfunction
   function automatic logic [127:0] expvec(input logic [63:0] a, input logic [1:0] sz, input logic q);
      logic [127:0] r;
      logic [63:0] d;
      int eb, ew;
      d = memval(a);
      eb = 1 << sz;
      ew = eb * 8;
      r = '0;
      for (int l = 0; l < (q ? 128 : 64) / ew; l++)
         for (int b = 0; b < eb; b++) r[l*ew + b*8 +: 8] = d[b*8 +: 8];
      return r;
   endfunction
   function automatic logic [31:0] mkinstr(input vec_t v);
      return (v.post ? 32'h0DE0C000 : 32'h0D60C000) | (32'(v.q) << 30) |
             (32'(v.size) << 10) | (32'(v.rm) << 16) | (32'(v.rn) << 5) | 32'(v.rt);
   endfunction

   assign mem_req_ready = (cyc % 3) != 1;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req_valid && mem_req_ready) begin
         if (nreq < 4) begin
            log_addr[nreq] = mem_req_addr;
            log_size[nreq] = mem_req_size;
         end
         nreq = nreq + 1;
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= memval(mem_req_addr);
      end else begin
         mem_rsp_valid <= 1'b0;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic got_done, got_ill, got_fault;
   logic [127:0] cap_a, cap_b;
   logic [4:0] cap_ai, cap_bi, cap_wi;
   logic [63:0] cap_wd;
   logic cap_we, cap_ws;

   task automatic run(input logic [31:0] w, input bit poke_busy);
      got_done = 0; got_ill = 0; got_fault = 0; cap_we = 0;
      @(negedge clk);
      nreq = 0; instr = w; start = 1;
      @(negedge clk);
      start = 0;
      for (int t = 0; t < 60; t++) begin
         if (poke_busy && t == 2) begin
            instr = 32'h0D60C000 | 32'd9; start = 1;
         end else start = 0;
         if (done || illegal || fault) begin
            got_done = done; got_ill = illegal; got_fault = fault;
            cap_a = vreg_a_data; cap_b = vreg_b_data;
            cap_ai = vreg_a_idx; cap_bi = vreg_b_idx;
            cap_we = base_wr_en; cap_ws = base_wr_sp; cap_wi = base_wr_idx; cap_wd = base_wr_data;
            break;
         end
         @(negedge clk);
      end
      start = 0;
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(idle && !done && !illegal && !fault && !base_wr_en && !mem_req_valid, "R9 reset state",
          {idle, done, illegal, fault, base_wr_en, mem_req_valid}, 6'b100000);
      rst_n = 1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [63:0] eb, es;
         v = VECS[i];
         sp_val = v.base;
         gpr_ra_data = v.base + GPR_BIAS;
         gpr_rb_data = v.off;
         eb = (v.rn == 5'd31) ? v.base : v.base + GPR_BIAS;
         es = 64'(1) << v.size;
         run(mkinstr(v), 1'b0);
         chk(got_done, "R8 done seen", 128'(got_done), 128'd1);
         chk(nreq == 2, "R2 two reads", 128'(nreq), 128'd2);
         chk(log_addr[0] == eb, "R5 R2 first addr", 128'(log_addr[0]), 128'(eb));
         chk(log_addr[1] == eb + es, "R2 second addr", 128'(log_addr[1]), 128'(eb + es));
         chk(log_size[0] == v.size, "R2 size", 128'(log_size[0]), 128'(v.size));
         chk(cap_ai == v.rt, "R3 first idx", 128'(cap_ai), 128'(v.rt));
         chk(cap_bi == v.rt + 5'd1, "R3 wrap idx", 128'(cap_bi), 128'(v.rt + 5'd1));
         chk(cap_a == expvec(eb, v.size, v.q), "R3 R4 first data", cap_a, expvec(eb, v.size, v.q));
         chk(cap_b == expvec(eb + es, v.size, v.q), "R3 R4 second data", cap_b, expvec(eb + es, v.size, v.q));
         chk(cap_we == v.post, "R6 wb enable", 128'(cap_we), 128'(v.post));
         if (v.post) begin
            logic [63:0] ew;
            ew = eb + ((v.rm == 5'd31) ? (es << 1) : v.off);
            chk(cap_wd == ew, "R6 wb data", 128'(cap_wd), 128'(ew));
            chk(cap_ws == (v.rn == 5'd31) && cap_wi == v.rn, "R6 wb target",
                128'({cap_ws, cap_wi}), 128'({v.rn == 5'd31, v.rn}));
         end
      end

      // R1 illegal: bit12 set
      run(32'h0D60D000, 1'b0);
      chk(got_ill && !got_done, "R1 illegal bit12", 128'(got_ill), 128'd1);
      chk(nreq == 0, "R1 no access", 128'(nreq), 128'd0);
      // R1 illegal: plain form with nonzero Rm
      run(32'h0D60C000 | (32'd3 << 16), 1'b0);
      chk(got_ill, "R1 plain rm nonzero", 128'(got_ill), 128'd1);

      // R5 misaligned stack base
      sp_val = 64'h8008;
      run(32'h0DE0C000 | (32'd31 << 16) | (32'd31 << 5) | 32'd2, 1'b0);
      chk(got_fault && !got_done, "R5 fault", 128'(got_fault), 128'd1);
      chk(nreq == 0 && !cap_we, "R5 no access", 128'(nreq), 128'd0);

      // R8 start while busy ignored
      gpr_ra_data = 64'h5000;
      run(32'h0D60C000 | (32'd1 << 5) | 32'd17, 1'b1);
      chk(got_done && cap_ai == 5'd17, "R8 busy start ignored", 128'(cap_ai), 128'd17);
      chk(nreq == 2, "R8 no extra reads", 128'(nreq), 128'd2);
      chk(idle && !done, "R8 back idle", 128'(idle), 128'd1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule